// File: doc/BRIEF.md
# NAND Flash Operation Launcher

This block sits between a host register bus and an abstracted NAND flash port and runs one flash operation at a time. The host first writes a command or address byte into a holding register. It then writes a one-hot operation code into a launch register. The sequencer performs one of six operations:

- a command latch beat
- an address latch beat
- a page transfer from the internal buffer to the flash
- a page transfer from the flash into the buffer
- an identification read
- a status read

When the flash ready/busy line shows ready, the block sets a sticky completion flag. It can also raise an interrupt, unless the interrupt is masked.

The internal page buffer is made of `NUM_SUB` sub-buffers of `SUB_BYTES` bytes each. A large page is moved as several transfers, and a select register picks the sub-buffer for each one. The host reaches the buffer through a pointer register and a data register. The flash port is a beat handshake: one byte moves per strobe cycle, and `nd_cle` or `nd_ale` qualifies a latch beat. A command byte of 0xFF is treated as a flash reset. Its completion is shown by the whole status register returning to zero.

Top module: `nand_op_launcher`

## Requirements
- R1: After reset, the status register reads 0, `irq` is low and every flash strobe (`nd_we`, `nd_re`, `nd_cle`, `nd_ale`) is low.
- R2: Launch code 0x01 issues exactly one `nd_we` beat with `nd_cle` high, carrying the holding byte. Launch code 0x02 does the same with `nd_ale` high.
- R3: On completion, status bit 15 (done) is set and status bits [5:0] hold the code that was launched. A status write with bit 15 at 0 clears done. A status write with bit 15 at 1 leaves it set. Writes never change the other status bits.
- R4: `irq` equals done while configuration bit 4 (mask) is 0. `irq` stays low while the mask is 1, and done is still set.
- R5: Status bit 14 (busy) is high from the accepted launch until completion. A launch written while busy starts nothing and leaves the stored code unchanged.
- R6: A launch code with no bit set, or with more than one bit set, is ignored.
- R7: Launch code 0x04 emits `SUB_BYTES` `nd_we` beats. They carry the bytes of the sub-buffer chosen by the select register, in increasing address order.
- R8: Launch code 0x08 performs `SUB_BYTES` `nd_re` beats. Each `nd_din` byte is stored into the selected sub-buffer in increasing order. A 4-sub-buffer page is moved by four transfers using select values 0 to 3.
- R9: Completion (done or busy release) waits until `nd_rb` is high after the operation's beats.
- R10: Launch code 0x10 fills bytes 0 to 15 of sub-buffer 0. In 8-bit mode (configuration bit 0 = 0), the first six ID bytes go to positions 0 to 5. In 16-bit mode (bit 0 = 1), they go to positions 0, 2, 4, 6, 8 and 10. All other positions are written as 0.
- R11: Launch code 0x20 performs one `nd_re` beat. It stores the status byte at buffer byte 0 and 0 at byte 1, so word 0 holds the status.
- R12: A command launch (0x01) whose holding byte is 0xFF completes by clearing the whole status register to 0. Done stays low.
- R13: The host register offsets are:
  - 0: holding byte
  - 1: launch
  - 2: status
  - 3: configuration
  - 4: sub-buffer select
  - 5: buffer byte pointer
  - 6: buffer data

  A write to the data register stores the byte at the pointer and advances the pointer. A read of the data register returns the byte at the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wen | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` |
| irq | output | 1 | Completion interrupt |
| nd_cle | output | 1 | Command latch qualifier |
| nd_ale | output | 1 | Address latch qualifier |
| nd_we | output | 1 | Write beat strobe |
| nd_re | output | 1 | Read beat strobe |
| nd_dout | output | 8 | Byte to flash |
| nd_din | input | 8 | Byte from flash, sampled during `nd_re` |
| nd_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions take for granted that `nd_din` is valid in every cycle in which `nd_re` is high. They also assume `nd_rb` is a level signal that the flash holds low only while it is working. The stimulus keeps to this: a bench flash model drives `nd_din` combinationally from its own read index and moves to the next index on each read beat, and `nd_rb` is changed only between operations or while the block waits for it. The host never writes buffer data or the holding byte while an operation is running. This keeps the host and sequencer buffer ports from colliding.

// File: rtl/nol_pkg.sv
package nol_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LATCH,
    SQ_XIN,
    SQ_XOUT,
    SQ_FILL,
    SQ_WAIT
  } nol_state_e;

  localparam logic [3:0] RA_HOLD   = 4'd0;
  localparam logic [3:0] RA_LAUNCH = 4'd1;
  localparam logic [3:0] RA_STAT   = 4'd2;
  localparam logic [3:0] RA_CFG    = 4'd3;
  localparam logic [3:0] RA_BSEL   = 4'd4;
  localparam logic [3:0] RA_PTR    = 4'd5;
  localparam logic [3:0] RA_DATA   = 4'd6;

  localparam int OPB_CMD  = 0;
  localparam int OPB_ADDR = 1;
  localparam int OPB_PIN  = 2;
  localparam int OPB_POUT = 3;
  localparam int OPB_ID   = 4;
  localparam int OPB_STAT = 5;

  localparam int CFGB_WIDE  = 0;
  localparam int CFGB_IMASK = 4;

  localparam logic [7:0] FLASH_RESET_OP = 8'hFF;
  localparam int         ID_BYTES       = 6;

endpackage

// File: rtl/nol_pagebuf.sv
module nol_pagebuf #(
  parameter int SUB_BYTES = 512,
  parameter int NUM_SUB   = 4,
  localparam int DEPTH    = SUB_BYTES * NUM_SUB,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [7:0]    e_wdata,
  output logic [7:0]    e_rdata
);

  logic [7:0]    mem [DEPTH];
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  // sequencer port wins; the host never writes while an operation runs
  always_comb begin
    wr_en   = e_we | h_we;
    wr_addr = e_we ? e_addr  : h_addr;
    wr_data = e_we ? e_wdata : h_wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign h_rdata = mem[h_addr];
  assign e_rdata = mem[e_addr];

endmodule

// File: rtl/nol_regs.sv
module nol_regs
  import nol_pkg::*;
#(
  parameter int SUB_BYTES = 512,
  parameter int NUM_SUB   = 4,
  localparam int AW       = $clog2(SUB_BYTES * NUM_SUB),
  localparam int BSW      = $clog2(NUM_SUB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     bus_addr,
  input  logic           bus_wen,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  input  logic           busy,
  input  logic           launch_acc,
  input  logic           fin,
  input  logic           fin_rst,
  input  logic [7:0]     buf_rdata,
  output logic           launch_req,
  output logic [5:0]     launch_code,
  output logic [7:0]     hold,
  output logic           wide,
  output logic           imask,
  output logic [BSW-1:0] bsel,
  output logic           done,
  output logic [5:0]     code,
  output logic           buf_we,
  output logic [AW-1:0]  buf_addr,
  output logic [7:0]     buf_wdata
);

  logic [7:0]     hold_n;
  logic           wide_n, imask_n, done_n;
  logic [BSW-1:0] bsel_n;
  logic [AW-1:0]  ptr, ptr_n;
  logic [5:0]     code_n;
  logic           wr_hold, wr_stat, wr_cfg, wr_bsel, wr_ptr, wr_data;
  logic           unused_wdata;

  assign unused_wdata = ^bus_wdata[14:8];

  always_comb begin
    wr_hold = bus_wen && (bus_addr == RA_HOLD);
    wr_stat = bus_wen && (bus_addr == RA_STAT);
    wr_cfg  = bus_wen && (bus_addr == RA_CFG);
    wr_bsel = bus_wen && (bus_addr == RA_BSEL);
    wr_ptr  = bus_wen && (bus_addr == RA_PTR);
    wr_data = bus_wen && (bus_addr == RA_DATA);
  end

  assign launch_req  = bus_wen && (bus_addr == RA_LAUNCH);
  assign launch_code = bus_wdata[5:0];
  assign buf_we      = wr_data;
  assign buf_addr    = ptr;
  assign buf_wdata   = bus_wdata[7:0];

  always_comb begin
    hold_n  = wr_hold ? bus_wdata[7:0] : hold;
    wide_n  = wr_cfg ? bus_wdata[CFGB_WIDE] : wide;
    imask_n = wr_cfg ? bus_wdata[CFGB_IMASK] : imask;
    bsel_n  = wr_bsel ? bus_wdata[BSW-1:0] : bsel;
    ptr_n   = ptr;
    if (wr_ptr)       ptr_n = bus_wdata[AW-1:0];
    else if (wr_data) ptr_n = ptr + 1'b1;
    done_n = done;
    if (fin && !fin_rst)           done_n = 1'b1;
    else if (fin_rst)              done_n = 1'b0;
    else if (wr_stat && !bus_wdata[15]) done_n = 1'b0;
    code_n = code;
    if (launch_acc)   code_n = launch_code;
    else if (fin_rst) code_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      wide  <= 1'b0;
      imask <= 1'b0;
      bsel  <= '0;
      ptr   <= '0;
      done  <= 1'b0;
      code  <= '0;
    end else begin
      hold  <= hold_n;
      wide  <= wide_n;
      imask <= imask_n;
      bsel  <= bsel_n;
      ptr   <= ptr_n;
      done  <= done_n;
      code  <= code_n;
    end
  end

  always_comb begin
    case (bus_addr)
      RA_HOLD: bus_rdata = {8'h00, hold};
      RA_STAT: bus_rdata = {done, busy, 8'h00, code};
      RA_CFG:  bus_rdata = {11'h000, imask, 3'b000, wide};
      RA_BSEL: bus_rdata = 16'(bsel);
      RA_PTR:  bus_rdata = 16'(ptr);
      RA_DATA: bus_rdata = {8'h00, buf_rdata};
      default: bus_rdata = 16'h0000;
    endcase
  end

endmodule

// File: rtl/nol_seq.sv
module nol_seq
  import nol_pkg::*;
#(
  parameter int SUB_BYTES = 512,
  parameter int NUM_SUB   = 4,
  localparam int CW       = $clog2(SUB_BYTES),
  localparam int BSW      = $clog2(NUM_SUB),
  localparam int AW       = CW + BSW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch_req,
  input  logic [5:0]     launch_code,
  input  logic [7:0]     hold,
  input  logic           wide,
  input  logic [BSW-1:0] bsel,
  input  logic [7:0]     nd_din,
  input  logic           nd_rb,
  input  logic [7:0]     e_rdata,
  output logic           launch_acc,
  output logic           busy,
  output logic           fin,
  output logic           fin_rst,
  output logic           nd_cle,
  output logic           nd_ale,
  output logic           nd_we,
  output logic           nd_re,
  output logic [7:0]     nd_dout,
  output logic           e_we,
  output logic [AW-1:0]  e_addr,
  output logic [7:0]     e_wdata
);

  nol_state_e    st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [5:0]    op, op_n;
  logic          rstop, rstop_n;
  logic [3:0]    pos;
  logic          take;
  logic [CW-1:0] fill_last;

  assign pos       = cnt[3:0];
  assign fill_last = op[OPB_ID] ? CW'(15) : CW'(1);
  assign busy      = (st != SQ_IDLE);

  always_comb begin
    if (op[OPB_ID])
      take = wide ? (!pos[0] && (pos[3:1] < 3'(ID_BYTES)))
                  : (pos < 4'(ID_BYTES));
    else
      take = (pos == 4'd0);
  end

  always_comb begin
    st_n       = st;
    cnt_n      = cnt;
    op_n       = op;
    rstop_n    = rstop;
    launch_acc = 1'b0;
    fin        = 1'b0;
    fin_rst    = 1'b0;
    nd_cle     = 1'b0;
    nd_ale     = 1'b0;
    nd_we      = 1'b0;
    nd_re      = 1'b0;
    nd_dout    = 8'h00;
    e_we       = 1'b0;
    e_addr     = {bsel, cnt};
    e_wdata    = nd_din;
    case (st)
      SQ_IDLE: begin
        if (launch_req && $onehot(launch_code)) begin
          launch_acc = 1'b1;
          op_n       = launch_code;
          rstop_n    = launch_code[OPB_CMD] && (hold == FLASH_RESET_OP);
          cnt_n      = '0;
          if (launch_code[OPB_CMD] || launch_code[OPB_ADDR]) st_n = SQ_LATCH;
          else if (launch_code[OPB_PIN])                     st_n = SQ_XIN;
          else if (launch_code[OPB_POUT])                    st_n = SQ_XOUT;
          else                                               st_n = SQ_FILL;
        end
      end
      SQ_LATCH: begin
        nd_we   = 1'b1;
        nd_cle  = op[OPB_CMD];
        nd_ale  = op[OPB_ADDR];
        nd_dout = hold;
        st_n    = SQ_WAIT;
      end
      SQ_XIN: begin
        nd_we   = 1'b1;
        nd_dout = e_rdata;
        if (cnt == CW'(SUB_BYTES - 1)) st_n = SQ_WAIT;
        else cnt_n = cnt + 1'b1;
      end
      SQ_XOUT: begin
        nd_re = 1'b1;
        e_we  = 1'b1;
        if (cnt == CW'(SUB_BYTES - 1)) st_n = SQ_WAIT;
        else cnt_n = cnt + 1'b1;
      end
      SQ_FILL: begin
        nd_re   = take;
        e_we    = 1'b1;
        e_addr  = AW'(pos);
        e_wdata = take ? nd_din : 8'h00;
        if (cnt == fill_last) st_n = SQ_WAIT;
        else cnt_n = cnt + 1'b1;
      end
      SQ_WAIT: begin
        if (nd_rb) begin
          fin     = 1'b1;
          fin_rst = rstop;
          st_n    = SQ_IDLE;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      op    <= '0;
      rstop <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      op    <= op_n;
      rstop <= rstop_n;
    end
  end

endmodule

// File: rtl/nand_op_launcher.sv
module nand_op_launcher
  import nol_pkg::*;
#(
  parameter int SUB_BYTES = 512,
  parameter int NUM_SUB   = 4,
  localparam int CW       = $clog2(SUB_BYTES),
  localparam int BSW      = $clog2(NUM_SUB),
  localparam int AW       = CW + BSW
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wen,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        nd_cle,
  output logic        nd_ale,
  output logic        nd_we,
  output logic        nd_re,
  output logic [7:0]  nd_dout,
  input  logic [7:0]  nd_din,
  input  logic        nd_rb
);

  logic [1:0]     rsync;
  logic           rst_q_n;
  logic           launch_req, launch_acc, seq_busy, fin, fin_rst;
  logic [5:0]     launch_code, stat_code;
  logic [7:0]     hold;
  logic           cfg_wide, cfg_imask, st_done;
  logic [BSW-1:0] bsel;
  logic           h_we, e_we;
  logic [AW-1:0]  h_addr, e_addr;
  logic [7:0]     h_wdata, h_rdata, e_wdata, e_rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q_n = rsync[1];

  assign irq = st_done && !cfg_imask;

  nol_regs #(.SUB_BYTES(SUB_BYTES), .NUM_SUB(NUM_SUB)) u_regs (
    .clk(clk), .rst_n(rst_q_n),
    .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy(seq_busy), .launch_acc(launch_acc), .fin(fin), .fin_rst(fin_rst),
    .buf_rdata(h_rdata),
    .launch_req(launch_req), .launch_code(launch_code), .hold(hold),
    .wide(cfg_wide), .imask(cfg_imask), .bsel(bsel),
    .done(st_done), .code(stat_code),
    .buf_we(h_we), .buf_addr(h_addr), .buf_wdata(h_wdata)
  );

  nol_seq #(.SUB_BYTES(SUB_BYTES), .NUM_SUB(NUM_SUB)) u_seq (
    .clk(clk), .rst_n(rst_q_n),
    .launch_req(launch_req), .launch_code(launch_code), .hold(hold),
    .wide(cfg_wide), .bsel(bsel), .nd_din(nd_din), .nd_rb(nd_rb),
    .e_rdata(e_rdata),
    .launch_acc(launch_acc), .busy(seq_busy), .fin(fin), .fin_rst(fin_rst),
    .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we(nd_we), .nd_re(nd_re),
    .nd_dout(nd_dout),
    .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata)
  );

  nol_pagebuf #(.SUB_BYTES(SUB_BYTES), .NUM_SUB(NUM_SUB)) u_buf (
    .clk(clk),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata), .e_rdata(e_rdata)
  );

endmodule

// File: rtl/nol_chk.sv
module nol_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       irq,
  input logic       imask,
  input logic       nd_we,
  input logic       nd_re,
  input logic       nd_cle,
  input logic       nd_ale,
  input logic       nd_rb,
  input logic [5:0] code
);

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(nd_we || nd_re)); // R5

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nd_cle && nd_ale)); // R2

  AST_LATCH_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (nd_cle || nd_ale) |-> nd_we); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nd_we && nd_re)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    imask |-> !irq); // R4

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R4

  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(nd_rb)); // R9

  AST_CODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(code)); // R5

endmodule

bind nand_op_launcher nol_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .busy(seq_busy), .done(st_done), .irq(irq),
  .imask(cfg_imask), .nd_we(nd_we), .nd_re(nd_re), .nd_cle(nd_cle),
  .nd_ale(nd_ale), .nd_rb(nd_rb), .code(stat_code)
);

// File: tb/sim_nand_op_launcher.sv
module sim_nand_op_launcher;

  localparam int SUB = 512;
  localparam int NS  = 4;

  logic        clk, rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wen;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq, nd_cle, nd_ale, nd_we, nd_re, nd_rb;
  logic [7:0]  nd_dout, nd_din;

  int nchk, nfail;

  nand_op_launcher #(.SUB_BYTES(SUB), .NUM_SUB(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we(nd_we), .nd_re(nd_re),
    .nd_dout(nd_dout), .nd_din(nd_din), .nd_rb(nd_rb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // flash model
  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) ^ (i >> 8));
  endfunction

  logic       model_clr;
  int         rd_idx, wcnt;
  logic [7:0] wlog [2048];
  logic       last_cle, last_ale;

  assign nd_din = pat(rd_idx);

  always @(posedge clk) begin
    if (model_clr) begin
      rd_idx <= 0;
      wcnt   <= 0;
    end else begin
      if (nd_re) rd_idx <= rd_idx + 1;
      if (nd_we) begin
        if (wcnt < 2048) wlog[wcnt] <= nd_dout;
        wcnt     <= wcnt + 1;
        last_cle <= nd_cle;
        last_ale <= nd_ale;
      end
    end
  end

  // bus helpers
  task automatic chk(input logic ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_buf(input int p, output logic [7:0] b);
    logic [15:0] t;
    wr(4'd5, 16'(p));
    rd(4'd6, t);
    b = t[7:0];
  endtask

  task automatic clr_model();
    @(negedge clk); model_clr = 1'b1;
    @(negedge clk); model_clr = 1'b0;
  endtask

  task automatic wait_idle(output logic [15:0] s);
    s = 16'h4000;
    for (int k = 0; k < 5000; k++) begin
      rd(4'd2, s);
      if (!s[14]) break;
    end
  endtask

  // command/address vectors: {code[5:0], byte[7:0]}
  localparam logic [13:0] VEC [6] = '{
    14'h0100, 14'h0212, 14'h0234, 14'h0130, 14'h02A5, 14'h0170
  };

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] s;
    logic [7:0]  b;
    int          bad;
    nchk = 0; nfail = 0;
    bus_addr = 0; bus_wen = 0; bus_wdata = 0; nd_rb = 1'b1; model_clr = 1'b0;
    last_cle = 0; last_ale = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_clr = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clr = 1'b0;

    // R1 reset state
    rd(4'd2, s);
    chk(s == 16'h0000, "R1 status after reset", s, 0);
    chk(!irq && !nd_we && !nd_re && !nd_cle && !nd_ale, "R1 irq/strobes after reset",
        {irq, nd_we, nd_re, nd_cle, nd_ale}, 0);

    // R13 host buffer access with pointer advance
    wr(4'd5, 16'd100);
    wr(4'd6, 16'h00C3);
    wr(4'd6, 16'h003C);
    rd_buf(101, b);
    chk(b == 8'h3C, "R13 buffer data at advanced pointer", b, 8'h3C);

    // R2/R3 vector table of latch operations
    foreach (VEC[i]) begin
      clr_model();
      wr(4'd0, {8'h00, VEC[i][7:0]});
      wr(4'd1, {10'h000, VEC[i][13:8]});
      wait_idle(s);
      chk(wcnt == 1 && wlog[0] == VEC[i][7:0], "R2 latch byte", wlog[0], VEC[i][7:0]);
      chk(last_cle == VEC[i][8] && last_ale == VEC[i][9], "R2 latch kind",
          {last_ale, last_cle}, VEC[i][9:8]);
      chk(s == (16'h8000 | 16'(VEC[i][13:8])), "R3 status after latch op", s,
          16'h8000 | 16'(VEC[i][13:8]));
      wr(4'd2, 16'h0000);
    end

    // R3 clear semantics
    wr(4'd0, 16'h0011); wr(4'd1, 16'h0002); wait_idle(s);
    wr(4'd2, 16'h8000); rd(4'd2, s);
    chk(s == 16'h8002, "R3 write bit15=1 keeps done", s, 16'h8002);
    // R4 irq and mask
    chk(irq == 1'b1, "R4 irq with mask clear", irq, 1);
    wr(4'd3, 16'h0010);
    rd(4'd2, s);
    chk(irq == 1'b0 && s[15], "R4 masked irq, flag kept", {irq, s[15]}, 1);
    wr(4'd3, 16'h0000);
    wr(4'd2, 16'h003F); rd(4'd2, s);
    chk(s == 16'h0002, "R3 write bit15=0 clears done only", s, 16'h0002);

    // R6 invalid codes
    clr_model();
    wr(4'd1, 16'h0003); wr(4'd1, 16'h0000);
    repeat (4) @(negedge clk);
    rd(4'd2, s);
    chk(s == 16'h0002 && wcnt == 0 && rd_idx == 0, "R6 invalid launch ignored", s, 16'h0002);

    // R5/R9 busy and ready wait
    clr_model();
    nd_rb = 1'b0;
    wr(4'd0, 16'h0090); wr(4'd1, 16'h0001);
    rd(4'd2, s);
    chk(s == 16'h4001, "R5 busy after launch", s, 16'h4001);
    wr(4'd1, 16'h0002);
    repeat (10) @(negedge clk);
    rd(4'd2, s);
    chk(s == 16'h4001, "R9 no completion while not ready", s, 16'h4001);
    chk(wcnt == 1, "R5 launch while busy ignored", wcnt, 1);
    nd_rb = 1'b1;
    wait_idle(s);
    chk(s == 16'h8001, "R9 completion after ready", s, 16'h8001);

    // R12 reset command clears whole status (done left set beforehand)
    wr(4'd0, 16'h00FF); wr(4'd1, 16'h0001); wait_idle(s);
    chk(s == 16'h0000 && !irq, "R12 reset completion reads zero", s, 0);

    // R8 four page-out transfers
    clr_model();
    for (int k = 0; k < NS; k++) begin
      wr(4'd4, 16'(k)); wr(4'd1, 16'h0008); wait_idle(s);
    end
    chk(rd_idx == SUB * NS, "R8 read beat count", rd_idx, SUB * NS);
    bad = 0;
    for (int p = 0; p < SUB * NS; p++) begin
      rd_buf(p, b);
      if (b != pat(p)) bad++;
    end
    chk(bad == 0, "R8 page-out buffer contents mismatches", bad, 0);
    wr(4'd2, 16'h0000);

    // R7 page-in from sub-buffer 2
    clr_model();
    wr(4'd4, 16'd2); wr(4'd1, 16'h0004); wait_idle(s);
    chk(wcnt == SUB, "R7 write beat count", wcnt, SUB);
    bad = 0;
    for (int p = 0; p < SUB; p++) if (wlog[p] != pat(2 * SUB + p)) bad++;
    chk(bad == 0, "R7 page-in order mismatches", bad, 0);

    // R10 ID read, 8-bit
    clr_model();
    wr(4'd1, 16'h0010); wait_idle(s);
    bad = 0;
    for (int p = 0; p < 16; p++) begin
      rd_buf(p, b);
      if (b != ((p < 6) ? pat(p) : 8'h00)) bad++;
    end
    chk(bad == 0, "R10 ID 8-bit layout mismatches", bad, 0);
    // R10 ID read, 16-bit
    clr_model();
    wr(4'd3, 16'h0001);
    wr(4'd1, 16'h0010); wait_idle(s);
    bad = 0;
    for (int p = 0; p < 16; p++) begin
      rd_buf(p, b);
      if (b != ((p % 2 == 0 && p < 12) ? pat(p / 2) : 8'h00)) bad++;
    end
    chk(bad == 0 && rd_idx == 6, "R10 ID 16-bit layout mismatches", bad, 0);
    wr(4'd3, 16'h0000);

    // R11 status read
    clr_model();
    wr(4'd1, 16'h0020); wait_idle(s);
    rd_buf(0, b);
    chk(b == pat(0), "R11 status byte", b, pat(0));
    rd_buf(1, b);
    chk(b == 8'h00, "R11 status high byte", b, 0);
    rd_buf(2, b);
    chk(b == pat(1) && rd_idx == 1, "R11 single beat, byte 2 untouched", b, pat(1));

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule